// File: doc/BRIEF.md
# Multi-rate TDM Time-Slot Interchange

The block switches 8-bit channels between serial TDM streams. Each frame, every channel that arrives on an active input pin is stored in a data memory at a 9-bit flat index. Each output slot looks up its own entry in a connection memory. That entry holds the flat index of a source channel, and the byte captured for that channel in the previous frame is shifted out, MSB first. Because the data memory is double-buffered by frame, every connection has the same one-frame delay.

One 9-bit index space serves three line rates. A 2-bit rate code selects 16 streams of 32 channels, 8 streams of 64 channels, or 4 streams of 128 channels. The stream number always occupies the upper bits of the index, so the split between stream and channel moves with the rate. The clock is the bit clock of the selected rate. A one-clock frame pulse aligns the frame, and a frame also restarts by itself when its length runs out. A small CPU port uses a 2-bit page register to extend a 7-bit address to 9 bits. Through this port the CPU reads the data memory and reads or writes the connection memory.

Top module: `tsi_switch`

## Requirements
- R1: Rate code `mode_i` 0 gives 16 streams of 32 channels, with the stream in index bits 8:5 and the channel in bits 4:0. Code 1 gives 8 streams of 64 channels, with the stream in bits 8:6. Code 2 gives 4 streams of 128 channels, with the stream in bits 8:7. Code 3 behaves as code 0.
- R2: A cycle with `fp_i` high is bit 7 (the MSB) of channel 0 in a new frame, even in the middle of a frame. Without a pulse, a new frame starts after 256, 512 or 1024 clocks at codes 0, 1 and 2. The first clock after reset starts a frame.
- R3: Each active input stream is captured MSB first. The byte is stored at index {stream, channel} in the bank of the current frame.
- R4: Bit b of output slot (stream s, channel c) is bit 7-b of the byte captured in the previous frame at the index held in connection entry {s, c}. It appears on `so_o[s]` one clock after its slot position.
- R5: An output pin with a number at or above the active stream count drives 1.
- R6: A change of `mode_i` takes effect only at the next frame start.
- R7: CPU space codes in `cpu_space_i` are: 0 for the page register (a write loads `cpu_wdata_i[1:0]`), 1 for the data memory, 2 for the connection memory, and 3 for nothing. A memory index is {page[1:0], `cpu_addr_i[6:0]`}.
- R8: A read request gives `cpu_rvalid_o` high and `cpu_rdata_o` valid in the next cycle. A read of the page register returns the page value. A read of the data memory returns the byte from the bank that is not being written. A read of space 3 returns 0.
- R9: A connection write affects slots that start after the write cycle. A slot that starts in the same cycle uses the old entry. CPU writes to the data memory are ignored.
- R10: Reset makes `so_o` all ones, `cpu_rvalid_o` low, the page 0, and both memories all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock at the selected rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_i | input | 1 | Frame start pulse |
| mode_i | input | 2 | Rate code |
| si_i | input | 16 | Serial input streams |
| so_o | output | 16 | Serial output streams |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU write when high, read when low |
| cpu_space_i | input | 2 | CPU target space |
| cpu_addr_i | input | 7 | CPU address within the page |
| cpu_wdata_i | input | 9 | CPU write data |
| cpu_rdata_o | output | 9 | CPU read data |
| cpu_rvalid_o | output | 1 | Read data valid |

## Verification
Two things can fall in the same cycle: a CPU write to a connection entry, and the output fetch of that entry at the first bit of its slot. The bench waits until its own frame tracker reaches the first bit of a chosen slot and issues the write in exactly that cycle. The behavioural model then expects the old source byte for that frame and the new source from the next frame on. This ordering is judged bit by bit on every clock, together with capture and fetch meeting in one cycle as two channel boundaries coincide across all streams.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic [1:0] {
    RATE_2M  = 2'd0,
    RATE_4M  = 2'd1,
    RATE_8M  = 2'd2,
    RATE_RSV = 2'd3
  } rate_e;

  localparam logic [1:0] SP_PAGE = 2'd0;
  localparam logic [1:0] SP_DATA = 2'd1;
  localparam logic [1:0] SP_CONN = 2'd2;

  // reserved rate code falls back to the slowest rate
  function automatic rate_e rate_fix(input logic [1:0] m);
    return (m == 2'd3) ? RATE_2M : rate_e'(m);
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
  import tsi_pkg::*;
#(
  parameter int POS_W     = 11,
  parameter int FRAME_MIN = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_i,
  input  logic [1:0]       mode_i,
  output logic             start_o,
  output logic [POS_W-1:0] pos_o,
  output rate_e            rate_o,
  output logic             bank_o
);
  logic [POS_W-1:0] pos_q, flen;
  rate_e            rate_q;
  logic             bank_q, past_ok_q;

  always_comb begin
    flen    = POS_W'(FRAME_MIN) << rate_q;
    start_o = fp_i || (pos_q == flen) || (pos_q == '0);
    pos_o   = start_o ? '0 : pos_q;
    rate_o  = start_o ? rate_fix(mode_i) : rate_q;
    bank_o  = start_o ? ~bank_q : bank_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      rate_q    <= RATE_2M;
      bank_q    <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      pos_q     <= pos_o + 1'b1;
      rate_q    <= rate_o;
      bank_q    <= bank_o;
      past_ok_q <= 1'b1;
    end
  end

  assert_mode_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !start_o) |-> (rate_o == $past(rate_o)));

  assert_bank_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && start_o) |-> (bank_o != $past(bank_o)));

  assert_pos_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !start_o) |-> (pos_o == $past(pos_o) + 1'b1));
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int N_PIN  = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_bank_i,
  input  logic [N_PIN-1:0]  wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i  [N_PIN],
  input  logic [DATA_W-1:0] wr_data_i [N_PIN],
  input  logic [IDX_W-1:0]  rd_idx_i  [N_PIN],
  output logic [DATA_W-1:0] rd_data_o [N_PIN],
  input  logic [IDX_W-1:0]  cpu_idx_i,
  output logic [DATA_W-1:0] cpu_data_o
);
  localparam int DEPTH = 2 ** (IDX_W + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int s = 0; s < N_PIN; s++)
        if (wr_en_i[s]) mem_q[{wr_bank_i, wr_idx_i[s]}] <= wr_data_i[s];
    end
  end

  // readers always see the bank completed in the previous frame
  always_comb begin
    for (int s = 0; s < N_PIN; s++) rd_data_o[s] = mem_q[{~wr_bank_i, rd_idx_i[s]}];
    cpu_data_o = mem_q[{~wr_bank_i, cpu_idx_i}];
  end

  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i[0] |=> (mem_q[$past({wr_bank_i, wr_idx_i[0]})] == $past(wr_data_i[0])));
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int N_PIN = 16,
  parameter int IDX_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] addr_i,
  input  logic [IDX_W-1:0] wdata_i,
  output logic [IDX_W-1:0] cpu_rdata_o,
  input  logic [IDX_W-1:0] rd_idx_i [N_PIN],
  output logic [IDX_W-1:0] rd_src_o [N_PIN]
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [IDX_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  always_comb begin
    for (int s = 0; s < N_PIN; s++) rd_src_o[s] = mem_q[rd_idx_i[s]];
    cpu_rdata_o = mem_q[addr_i];
  end

  assert_cm_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int N_PIN     = 16,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 9,
  parameter int CADDR_W   = 7,
  parameter int POS_W     = 11,
  parameter int FRAME_MIN = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fp_i,
  input  logic [1:0]         mode_i,
  input  logic [N_PIN-1:0]   si_i,
  output logic [N_PIN-1:0]   so_o,
  input  logic               cpu_req_i,
  input  logic               cpu_we_i,
  input  logic [1:0]         cpu_space_i,
  input  logic [CADDR_W-1:0] cpu_addr_i,
  input  logic [IDX_W-1:0]   cpu_wdata_i,
  output logic [IDX_W-1:0]   cpu_rdata_o,
  output logic               cpu_rvalid_o
);
  localparam int BIT_W     = $clog2(DATA_W);
  localparam int STR_W     = $clog2(N_PIN);
  localparam int CH_BASE_W = IDX_W - STR_W;
  localparam int PAGE_W    = IDX_W - CADDR_W;

  logic             start;
  logic [POS_W-1:0] pos;
  rate_e            rate;
  logic             bank;

  tsi_frame_timer #(.POS_W(POS_W), .FRAME_MIN(FRAME_MIN)) u_timer (
    .clk_i, .rst_ni, .fp_i, .mode_i,
    .start_o(start), .pos_o(pos), .rate_o(rate), .bank_o(bank)
  );

  logic [BIT_W-1:0]       bit_idx;
  logic [POS_W-BIT_W-1:0] chan_all;
  assign bit_idx  = pos[BIT_W-1:0];
  assign chan_all = pos[POS_W-1:BIT_W];

  logic [N_PIN-1:0]   act, wr_en, nxt, so_q;
  logic [IDX_W-1:0]   lidx    [N_PIN];
  logic [IDX_W-1:0]   src     [N_PIN];
  logic [DATA_W-1:0]  in_byte [N_PIN];
  logic [DATA_W-1:0]  rd_data [N_PIN];
  logic [DATA_W-1:0]  hold_q  [N_PIN];
  logic [DATA_W-2:0]  sh_q    [N_PIN];
  int                 n_act, cw, chan;

  // stream number sits above a channel field whose width follows the rate
  always_comb begin
    n_act = N_PIN >> int'(rate);
    cw    = CH_BASE_W + int'(rate);
    chan  = int'(chan_all) & ((1 << cw) - 1);
    for (int s = 0; s < N_PIN; s++) begin
      act[s]     = (s < n_act);
      lidx[s]    = IDX_W'((s << cw) | chan);
      in_byte[s] = {sh_q[s], si_i[s]};
      wr_en[s]   = act[s] && (bit_idx == BIT_W'(DATA_W - 1));
      nxt[s]     = (bit_idx == '0) ? rd_data[s][DATA_W-1]
                                   : hold_q[s][DATA_W-1-int'(bit_idx)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      so_q <= '1;
      for (int s = 0; s < N_PIN; s++) begin
        sh_q[s]   <= '0;
        hold_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < N_PIN; s++) begin
        sh_q[s] <= in_byte[s][DATA_W-2:0];
        if (bit_idx == '0) hold_q[s] <= rd_data[s];
        so_q[s] <= act[s] ? nxt[s] : 1'b1;
      end
    end
  end
  assign so_o = so_q;

  // CPU port
  logic [PAGE_W-1:0]  page_q;
  logic [IDX_W-1:0]   cpu_idx, cm_cpu, rdata_q;
  logic [DATA_W-1:0]  dm_cpu;
  logic               cpu_rd, cpu_wr, cm_we, rvalid_q;

  assign cpu_rd  = cpu_req_i && !cpu_we_i;
  assign cpu_wr  = cpu_req_i && cpu_we_i;
  assign cm_we   = cpu_wr && (cpu_space_i == SP_CONN);
  assign cpu_idx = {page_q, cpu_addr_i};

  tsi_data_mem #(.N_PIN(N_PIN), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dmem (
    .clk_i, .rst_ni,
    .wr_bank_i(bank), .wr_en_i(wr_en), .wr_idx_i(lidx), .wr_data_i(in_byte),
    .rd_idx_i(src), .rd_data_o(rd_data),
    .cpu_idx_i(cpu_idx), .cpu_data_o(dm_cpu)
  );

  tsi_conn_mem #(.N_PIN(N_PIN), .IDX_W(IDX_W)) u_cmem (
    .clk_i, .rst_ni,
    .we_i(cm_we), .addr_i(cpu_idx), .wdata_i(cpu_wdata_i), .cpu_rdata_o(cm_cpu),
    .rd_idx_i(lidx), .rd_src_o(src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cpu_rd;
      if (cpu_wr && (cpu_space_i == SP_PAGE)) page_q <= cpu_wdata_i[PAGE_W-1:0];
      if (cpu_rd) begin
        case (cpu_space_i)
          SP_PAGE: rdata_q <= IDX_W'(page_q);
          SP_DATA: rdata_q <= IDX_W'(dm_cpu);
          SP_CONN: rdata_q <= cm_cpu;
          default: rdata_q <= '0;
        endcase
      end
    end
  end
  assign cpu_rdata_o  = rdata_q;
  assign cpu_rvalid_o = rvalid_q;

  assert_idle_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate == RATE_8M) |=> (&so_o[N_PIN-1:N_PIN/4]));

  assert_rvalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd |=> cpu_rvalid_o);

  assert_no_rvalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rd |=> !cpu_rvalid_o);

  assert_page_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr && cpu_space_i == SP_PAGE) |=> (page_q == $past(cpu_wdata_i[PAGE_W-1:0])));
endmodule

// File: tb/tsi_switch_tb_top.sv
module tsi_switch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fp_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [15:0] si_i = '0;
  logic [15:0] so_o;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_space = 2'd0;
  logic [6:0]  cpu_addr = '0;
  logic [8:0]  cpu_wdata = '0;
  logic [8:0]  cpu_rdata;
  logic        cpu_rvalid;

  always #5 clk = ~clk;

  tsi_switch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fp_i(fp_i), .mode_i(mode_i), .si_i(si_i), .so_o(so_o),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_space_i(cpu_space), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cpu_rvalid_o(cpu_rvalid)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int flen(input int m); return 256 << m; endfunction
  function automatic int fixm(input int m); return (m == 3) ? 0 : m; endfunction
  function automatic int nstr(input int m); return 16 >> m; endfunction
  function automatic int nch(input int m);  return 32 << m; endfunction
  function automatic logic [7:0] pat(input int fr, input int s, input int ch);
    return 8'((fr * 37 + s * 11 + ch * 3 + 5) & 255);
  endfunction

  // ---------------- stimulus driver ----------------
  int d_pos = -1, d_mode = 0, d_frame = 0;
  bit fp_req = 0;
  int mode_req = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      d_pos = -1; d_mode = 0; d_frame = 0;
      fp_i <= 1'b0; si_i <= '0;
    end else begin
      automatic bit f = fp_req;
      automatic int np;
      fp_req = 0;
      np = f ? 0 : (d_pos + 1) % flen(d_mode);
      if (np == 0) begin
        d_mode = fixm(mode_req);
        d_frame++;
      end
      fp_i   <= f;
      mode_i <= 2'(mode_req);
      for (int s = 0; s < 16; s++) begin
        automatic logic [7:0] b = pat(d_frame, s, np / 8);
        si_i[s] <= b[7 - (np % 8)];
      end
      d_pos = np;
    end
  end

  // ---------------- behavioural reference ----------------
  int          m_prev, m_mode, m_page;
  bit          m_bank;
  logic [7:0]  m_dm [2][512];
  int          m_cm [512];
  logic [7:0]  m_sh [16];
  logic [7:0]  m_hold [16];
  logic [15:0] exp_so = '1, exp_mask = '0;
  bit          exp_rv = 0;
  logic [8:0]  exp_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = -1; m_mode = 0; m_page = 0; m_bank = 0;
      for (int i = 0; i < 512; i++) begin
        m_dm[0][i] = '0; m_dm[1][i] = '0; m_cm[i] = 0;
      end
      for (int s = 0; s < 16; s++) begin m_sh[s] = '0; m_hold[s] = '0; end
      exp_so = '1; exp_mask = '0; exp_rv = 0; exp_rd = '0;
    end else begin
      automatic int pos = fp_i ? 0 : (m_prev + 1) % flen(m_mode);
      automatic int b, ch, idx;
      if (pos == 0) begin
        m_mode = fixm(int'(mode_i));
        m_bank = ~m_bank;
      end
      b  = pos % 8;
      ch = pos / 8;
      for (int s = 0; s < 16; s++) begin
        m_sh[s] = {m_sh[s][6:0], si_i[s]};
        if (s < nstr(m_mode)) begin
          idx = s * nch(m_mode) + ch;
          if (b == 7) m_dm[m_bank][idx] = m_sh[s];
          if (b == 0) m_hold[s] = m_dm[~m_bank][m_cm[idx]];
          exp_so[s]   = m_hold[s][7 - b];
          exp_mask[s] = 1'b1;
        end else begin
          exp_so[s]   = 1'b1;
          exp_mask[s] = 1'b0;
        end
      end
      exp_rv = cpu_req && !cpu_we;
      idx = m_page * 128 + int'(cpu_addr);
      if (cpu_req) begin
        if (cpu_we) begin
          if (cpu_space == 2'd0) m_page = int'(cpu_wdata) & 3;
          else if (cpu_space == 2'd2) m_cm[idx] = int'(cpu_wdata);
        end else begin
          case (cpu_space)
            2'd0: exp_rd = 9'(m_page);
            2'd1: exp_rd = {1'b0, m_dm[~m_bank][idx]};
            2'd2: exp_rd = 9'(m_cm[idx]);
            default: exp_rd = '0;
          endcase
        end
      end
      m_prev = pos;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      // R4 data path, R2 frame timing and R6 rate switch all show up here
      chk((so_o & exp_mask) == (exp_so & exp_mask), "R4 switched output bits", 32'(so_o), 32'(exp_so));
      chk((so_o & ~exp_mask) == ~exp_mask, "R5 idle outputs high", 32'(so_o), 32'(exp_so));
      chk(cpu_rvalid == exp_rv, "R8 read valid", 32'(cpu_rvalid), 32'(exp_rv));
      if (exp_rv) chk(cpu_rdata == exp_rd, "R8 read data", 32'(cpu_rdata), 32'(exp_rd));
    end
  end

  // ---------------- tasks ----------------
  task automatic tick(); @(negedge clk); #1; endtask
  task automatic wait_n(input int n); repeat (n) tick(); endtask

  task automatic cpu_write(input logic [1:0] sp, input int a, input int d);
    cpu_req = 1; cpu_we = 1; cpu_space = sp; cpu_addr = 7'(a); cpu_wdata = 9'(d);
    tick();
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic cpu_read(input logic [1:0] sp, input int a, output logic [8:0] rd);
    cpu_req = 1; cpu_we = 0; cpu_space = sp; cpu_addr = 7'(a);
    tick();
    rd = cpu_rdata;
    cpu_req = 0;
  endtask

  task automatic dm_check(input int s, input int ch, input string tag);
    automatic int idx = s * nch(d_mode) + ch;
    automatic int fr;
    automatic logic [8:0] rd;
    cpu_write(2'd0, 0, idx >> 7);
    fr = d_frame - 1;
    cpu_read(2'd1, idx & 127, rd);
    chk(rd == {1'b0, pat(fr, s, ch)}, tag, 32'(rd), 32'(pat(fr, s, ch)));
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [8:0] rd;
    repeat (4) @(negedge clk);
    chk(so_o == 16'hFFFF, "R10 reset outputs", 32'(so_o), 32'hFFFF);
    chk(cpu_rvalid == 1'b0, "R10 reset rvalid", 32'(cpu_rvalid), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    tick();

    cpu_read(2'd2, 5, rd);
    chk(rd == 9'd0, "R10 connection entry cleared", 32'(rd), 0);
    cpu_read(2'd0, 0, rd);
    chk(rd == 9'd0, "R10 page cleared", 32'(rd), 0);
    cpu_write(2'd0, 0, 3);
    cpu_read(2'd0, 0, rd);
    chk(rd == 9'd3, "R7 page register", 32'(rd), 3);

    for (int i = 0; i < 512; i++) begin
      if (i % 128 == 0) cpu_write(2'd0, 0, i >> 7);
      cpu_write(2'd2, i & 127, (i * 5 + 77) % 512);
    end
    wait_n(600);
    dm_check(9, 17, "R3 capture at stream/channel index");
    dm_check(15, 31, "R1 rate 0 top index");
    dm_check(0, 0, "R3 first channel");
    cpu_write(2'd0, 0, 2);
    cpu_read(2'd2, 300 & 127, rd);
    chk(rd == 9'((300 * 5 + 77) % 512), "R7 paged connection read", 32'(rd), 32'((300 * 5 + 77) % 512));

    // CPU write into data space must not land
    cpu_write(2'd0, 0, (9 * 32 + 17) >> 7);
    cpu_write(2'd1, (9 * 32 + 17) & 127, 9'h055);
    dm_check(9, 17, "R9 data memory write ignored");
    cpu_read(2'd3, 0, rd);
    chk(rd == 9'd0, "R8 empty space reads zero", 32'(rd), 0);

    // R9 collision: connection write in the fetch cycle of its own slot
    cpu_write(2'd0, 0, 0);
    do tick(); while (!(d_pos == 80 && d_mode == 0));
    cpu_req = 1; cpu_we = 1; cpu_space = 2'd2; cpu_addr = 7'(3 * 32 + 10); cpu_wdata = 9'd200;
    tick();
    cpu_req = 0; cpu_we = 0;
    wait_n(600);

    // R6: rate request in mid-frame, applied at next start
    do tick(); while (d_pos != 100);
    mode_req = 1;
    wait_n(3 * 512);
    dm_check(7, 63, "R1 rate 1 top stream");
    dm_check(2, 40, "R1 rate 1 channel field");

    mode_req = 2;
    wait_n(2 * 1024 + 600);
    dm_check(3, 127, "R1 rate 2 top index");
    dm_check(1, 5, "R1 rate 2 channel field");

    // R2: early frame pulse
    do tick(); while (d_pos != 300);
    fp_req = 1;
    wait_n(2 * 1024 + 100);
    dm_check(2, 100, "R2 realigned capture");

    mode_req = 3;
    wait_n(2 * 1024 + 600);
    dm_check(12, 20, "R1 code 3 as rate 0");
    wait_n(20);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule